// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block gathers per-pin interrupt events from a bank of up to 184 GPIO pins, each produced by per-pin trigger logic outside the block. Every event sets a sticky pending flag for its pin. The flags are folded into a 46-bit summary, one bit for each group of four adjacent pins. The summary is presented as two 32-bit status words, and a single shared interrupt line toward the host is driven from it. Software finds the active group from the summary and then clears the pin flags through the per-pin clear inputs.

A master control word holds three things: an end-of-interrupt (EOI) command, a blocking enable and a 12-bit blocking length. Writing EOI drops the host line for one cycle so that the host's interrupt controller sees a fresh edge when events are still pending. When blocking is enabled, any write to a pin's debounce setting opens a timed window. During the window, no pin can raise a new pending flag, and the interrupt enable read back for the written pin is forced to 0. Software can poll that bit to learn when the debounce logic has settled.

Top module: `gsum_aggregator`

## Requirements
- R1: After synchronous reset, both status words, the host line and the master readback are all 0.
- R2: Summary bit n is the OR of the pending flags of pins 4n to 4n+3. Status word 0 carries summary bits 31..0. Status word 1 carries summary bits 45..32 in its bits 13..0, and its bits 31..14 read as 0.
- R3: A pending flag sets on its pin's event pulse and holds until that pin's clear input is high. If set and clear arrive in the same cycle, set wins.
- R4: The host line is registered. It is high one cycle after any summary bit is set, provided no EOI was written in that cycle.
- R5: A master write with bit 31 set (EOI) forces the host line low in the next cycle. In the cycle after that, the line follows the summary again. Bit 31 always reads back as 0.
- R6: Master layout: blocking length in bits 11..0 and blocking enable in bit 16, both read back as written. Every master write, including an EOI write, loads these fields. All other bits are ignored and read as 0.
- R7: When the enable is 1 and the length L is nonzero, a debounce write opens a window over the L clock edges that follow it. Events sampled at those edges are dropped for all pins.
- R8: During a window, the interrupt enable read back for the last written pin is 0. Every other pin, and that pin once the window has ended, reads back its stored enable unchanged.
- R9: A debounce write opens no window when the enable is 0 or the length is 0.
- R10: A debounce write during an open window restarts the count at the full length.
- R11: An event dropped in a window is discarded. It does not appear in the summary after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_evt | input | NUM_PINS (184) | Per-pin event pulses from the trigger logic |
| pin_clr | input | NUM_PINS (184) | Per-pin pending clear |
| pin_ien | input | NUM_PINS (184) | Stored per-pin interrupt enable bits |
| dbnc_wr | input | 1 | A debounce field was written this cycle |
| dbnc_pin | input | PIN_IDX_W (8) | Index of the pin whose debounce field was written |
| mst_wr | input | 1 | Master control word write strobe |
| mst_wdata | input | 32 | Master control write data |
| mst_rdata | output | 32 | Master control readback |
| sts_word0 | output | 32 | Summary bits 31..0 |
| sts_word1 | output | 32 | Summary bits 45..32, upper bits zero |
| pin_ien_rd | output | NUM_PINS (184) | Interrupt enable readback, with the blocked pin forced to 0 |
| host_irq | output | 1 | Shared interrupt line to the host |

## Verification
The assertions assume that the trigger logic outside the block delivers events and clears as pulses sampled on clock edges, and that a debounce pin index names a real pin. The window-count properties also assume that the master word does not change in the same cycle as a debounce write. The stimulus respects all of this: it drives every input one nanosecond after a rising edge, holds each strobe for exactly one cycle, uses only pin indices below 184, and keeps master writes and debounce writes in separate cycles.

// File: rtl/gsum_pkg.sv
package gsum_pkg;
    // Master control word layout
    localparam int REG_W   = 32;
    localparam int LEN_W   = 12;
    localparam int EN_BIT  = 16;
    localparam int EOI_BIT = 31;

    typedef struct packed {
        logic             en;
        logic [LEN_W-1:0] len;
    } blk_cfg_t;

    function automatic blk_cfg_t decode_cfg(input logic [REG_W-1:0] w);
        blk_cfg_t c;
        c.en  = w[EN_BIT];
        c.len = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_cfg(input blk_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT] = c.en;
        w[LEN_W-1:0] = c.len;
        return w;
    endfunction
endpackage

// File: rtl/gsum_pend_bank.sv
module gsum_pend_bank #(
    parameter int NUM_PINS     = 184,
    parameter int PINS_PER_GRP = 4,
    parameter int NUM_GRP      = NUM_PINS / PINS_PER_GRP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] evt,
    input  logic [NUM_PINS-1:0] clr,
    input  logic                blocked,
    output logic [NUM_GRP-1:0]  grp_sum,
    output logic                any_grp
);
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] evt_ok;

    assign evt_ok = blocked ? '0 : evt;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr) | evt_ok;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_sum[g] = |pend_q[g*PINS_PER_GRP +: PINS_PER_GRP];
    end

    assign any_grp = |grp_sum;

    // R3: a pending flag only falls when its clear was high
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        ((~pend_q & $past(pend_q) & ~$past(clr)) == '0));

    // R7: no flag rises on an edge sampled inside a window
    a_r7_drop: assert property (@(posedge clk) disable iff (rst)
        blocked |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/gsum_win.sv
module gsum_win
    import gsum_pkg::*;
#(
    parameter int NUM_PINS  = 184,
    parameter int PIN_IDX_W = $clog2(NUM_PINS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dbnc_wr,
    input  logic [PIN_IDX_W-1:0] dbnc_pin,
    input  blk_cfg_t             cfg,
    input  logic [NUM_PINS-1:0]  pin_ien,
    output logic                 blocked,
    output logic [NUM_PINS-1:0]  pin_ien_rd
);
    logic [LEN_W-1:0]     cnt_q;
    logic [PIN_IDX_W-1:0] pin_q;
    logic                 load;

    assign load = dbnc_wr && cfg.en && (cfg.len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pin_q <= '0;
        end else if (load) begin
            cnt_q <= cfg.len;
            pin_q <= dbnc_pin;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blocked = (cnt_q != '0);

    always_comb begin
        pin_ien_rd = pin_ien;
        if (blocked) pin_ien_rd[pin_q] = 1'b0;
    end

    // R10: an open window counts down by one per edge unless reloaded
    a_r10_count: assert property (@(posedge clk) disable iff (rst)
        (blocked && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9: a write that cannot open a window leaves a closed window closed
    a_r9_no_open: assert property (@(posedge clk) disable iff (rst)
        (dbnc_wr && (!cfg.en || cfg.len == '0) && !blocked) |=> !blocked);
endmodule

// File: rtl/gsum_irq_ctl.sv
module gsum_irq_ctl
    import gsum_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mst_wr,
    input  logic [REG_W-1:0] mst_wdata,
    input  logic             any_grp,
    output blk_cfg_t         cfg,
    output logic [REG_W-1:0] mst_rdata,
    output logic             host_irq
);
    logic eoi_wr;

    assign eoi_wr = mst_wr && mst_wdata[EOI_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            host_irq <= 1'b0;
        end else begin
            if (mst_wr) cfg <= decode_cfg(mst_wdata);
            host_irq <= any_grp && !eoi_wr;
        end
    end

    assign mst_rdata = encode_cfg(cfg);

    // R5: an EOI write drops the line in the following cycle
    a_r5_eoi_drop: assert property (@(posedge clk) disable iff (rst)
        eoi_wr |=> !host_irq);

    // R4: the line is only high after a set summary and no EOI
    a_r4_cause: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> ($past(any_grp) && !$past(eoi_wr)));
endmodule

// File: rtl/gsum_aggregator.sv
module gsum_aggregator
    import gsum_pkg::*;
#(
    parameter int NUM_PINS     = 184,
    parameter int PINS_PER_GRP = 4,
    parameter int PIN_IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PINS-1:0]  pin_evt,
    input  logic [NUM_PINS-1:0]  pin_clr,
    input  logic [NUM_PINS-1:0]  pin_ien,
    input  logic                 dbnc_wr,
    input  logic [PIN_IDX_W-1:0] dbnc_pin,
    input  logic                 mst_wr,
    input  logic [REG_W-1:0]     mst_wdata,
    output logic [REG_W-1:0]     mst_rdata,
    output logic [REG_W-1:0]     sts_word0,
    output logic [REG_W-1:0]     sts_word1,
    output logic [NUM_PINS-1:0]  pin_ien_rd,
    output logic                 host_irq
);
    localparam int NUM_GRP = NUM_PINS / PINS_PER_GRP;

    logic [NUM_GRP-1:0]   grp_sum;
    logic                 any_grp;
    logic                 blocked;
    blk_cfg_t             cfg;
    logic [2*REG_W-1:0]   sum_wide;

    gsum_pend_bank #(
        .NUM_PINS(NUM_PINS), .PINS_PER_GRP(PINS_PER_GRP), .NUM_GRP(NUM_GRP)
    ) u_pend (
        .clk(clk), .rst(rst), .evt(pin_evt), .clr(pin_clr),
        .blocked(blocked), .grp_sum(grp_sum), .any_grp(any_grp)
    );

    gsum_win #(
        .NUM_PINS(NUM_PINS), .PIN_IDX_W(PIN_IDX_W)
    ) u_win (
        .clk(clk), .rst(rst), .dbnc_wr(dbnc_wr), .dbnc_pin(dbnc_pin),
        .cfg(cfg), .pin_ien(pin_ien), .blocked(blocked),
        .pin_ien_rd(pin_ien_rd)
    );

    gsum_irq_ctl u_irq (
        .clk(clk), .rst(rst), .mst_wr(mst_wr), .mst_wdata(mst_wdata),
        .any_grp(any_grp), .cfg(cfg), .mst_rdata(mst_rdata),
        .host_irq(host_irq)
    );

    always_comb begin
        sum_wide = '0;
        sum_wide[NUM_GRP-1:0] = grp_sum;
    end

    assign sts_word0 = sum_wide[REG_W-1:0];
    assign sts_word1 = sum_wide[2*REG_W-1:REG_W];

    // R2: any set status bit implies the host line follows one cycle later unless EOI
    a_r2_sum_to_line: assert property (@(posedge clk) disable iff (rst)
        ((sts_word0 != '0 || sts_word1 != '0) && !mst_wr) |=> host_irq);
endmodule

// File: tb/gsum_aggregator_tb_top.sv
module gsum_aggregator_tb_top;
    localparam int NP = 184;

    logic            clk = 1'b0;
    logic            rst;
    logic [NP-1:0]   pin_evt, pin_clr, pin_ien, pin_ien_rd;
    logic            dbnc_wr, mst_wr, host_irq;
    logic [7:0]      dbnc_pin;
    logic [31:0]     mst_wdata, mst_rdata, sts_word0, sts_word1;

    always #5 clk = ~clk;

    gsum_aggregator dut_i (
        .clk(clk), .rst(rst), .pin_evt(pin_evt), .pin_clr(pin_clr),
        .pin_ien(pin_ien), .dbnc_wr(dbnc_wr), .dbnc_pin(dbnc_pin),
        .mst_wr(mst_wr), .mst_wdata(mst_wdata), .mst_rdata(mst_rdata),
        .sts_word0(sts_word0), .sts_word1(sts_word1),
        .pin_ien_rd(pin_ien_rd), .host_irq(host_irq)
    );

    typedef struct {
        string       req;
        int          sel;   // 0 word0, 1 word1, 2 line, 3 master, 4 enable bit
        int          idx;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic expect_item(input string req, input int sel, input int idx,
                               input logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.idx = idx; it.exp = exp;
        sb_q.push_back(it);
    endtask

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin : mon
        item_t it;
        logic [31:0] act;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.sel)
                0: act = sts_word0;
                1: act = sts_word1;
                2: act = {31'b0, host_irq};
                3: act = mst_rdata;
                default: act = {31'b0, pin_ien_rd[it.idx]};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d idx=%0d actual=%h expected=%h",
                         it.req, it.sel, it.idx, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic evt_pulse(input int p);
        pin_evt[p] = 1'b1;
        step();
        pin_evt = '0;
    endtask

    task automatic clr_all();
        pin_clr = '1;
        step();
        pin_clr = '0;
    endtask

    task automatic mst_write(input logic [31:0] d);
        mst_wr = 1'b1;
        mst_wdata = d;
        step();
        mst_wr = 1'b0;
    endtask

    task automatic dbnc(input int p);
        dbnc_wr = 1'b1;
        dbnc_pin = p[7:0];
        step();
        dbnc_wr = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pin_evt = '0; pin_clr = '0; pin_ien = '1;
        dbnc_wr = 1'b0; dbnc_pin = '0; mst_wr = 1'b0; mst_wdata = '0;
        repeat (3) step();
        rst = 1'b0;
        expect_item("R1", 0, 0, 32'h0);
        expect_item("R1", 1, 0, 32'h0);
        expect_item("R1", 2, 0, 32'h0);
        expect_item("R1", 3, 0, 32'h0);
        step();

        // R2/R4: pin 5 -> group 1
        evt_pulse(5);
        expect_item("R2", 0, 0, 32'h2);
        expect_item("R4", 2, 0, 32'h0);
        step();
        expect_item("R4", 2, 0, 32'h1);
        // R2: pin 7 shares group 1
        evt_pulse(7);
        expect_item("R2", 0, 0, 32'h2);
        // R2: pins 128 and 183 -> groups 32 and 45
        pin_evt[128] = 1'b1;
        evt_pulse(183);
        expect_item("R2", 1, 0, 32'h0000_2001);

        // R3: clear pins 5 and 7, with pin 5 set again in the same cycle
        pin_clr[5] = 1'b1; pin_clr[7] = 1'b1;
        evt_pulse(5);
        pin_clr = '0;
        step(); step();
        expect_item("R3", 0, 0, 32'h2);
        pin_clr[5] = 1'b1;
        step();
        pin_clr = '0;
        expect_item("R3", 0, 0, 32'h0);

        // R5: EOI drops the line one cycle, then it returns
        step();
        expect_item("R5", 2, 0, 32'h1);
        mst_write(32'h8000_0000);
        expect_item("R5", 2, 0, 32'h0);
        expect_item("R5", 3, 0, 32'h0);
        step();
        expect_item("R5", 2, 0, 32'h1);

        clr_all();
        step();
        expect_item("R4", 2, 0, 32'h0);

        // R6: length 5, enable set, stray bits ignored
        mst_write(32'h7F01_F005);
        expect_item("R6", 3, 0, 32'h0001_0005);

        // R7/R8/R11: window of five edges
        dbnc(10);
        expect_item("R8", 4, 10, 32'h0);
        expect_item("R8", 4, 11, 32'h1);
        evt_pulse(20);
        expect_item("R7", 0, 0, 32'h0);
        step(); step(); step();
        evt_pulse(0);
        expect_item("R11", 0, 0, 32'h0);
        expect_item("R11", 1, 0, 32'h0);
        expect_item("R8", 4, 10, 32'h1);
        evt_pulse(0);
        expect_item("R7", 0, 0, 32'h1);

        // R10: restart in the middle of a window
        clr_all();
        dbnc(3);
        step(); step(); step();
        dbnc(3);
        step(); step(); step(); step();
        expect_item("R10", 4, 3, 32'h0);
        evt_pulse(1);
        expect_item("R10", 0, 0, 32'h0);
        expect_item("R10", 4, 3, 32'h1);

        // R9: zero length
        mst_write(32'h0001_0000);
        dbnc(7);
        expect_item("R9", 4, 7, 32'h1);
        evt_pulse(7);
        expect_item("R9", 0, 0, 32'h2);
        // R9: enable clear
        clr_all();
        mst_write(32'h0000_0009);
        dbnc(9);
        evt_pulse(9);
        expect_item("R9", 0, 0, 32'h4);

        step(); step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule